// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

Two single-word mailboxes let two independently clocked ports pass a word to each other outside the FIFO path. Port A deposits a word in mailbox 1 and port B collects it; port B deposits a word in mailbox 2 and port A collects it. Each mailbox carries a full flag. The writer's access sets the flag, and the reader's access clears it. The set and clear events each cross into the other clock domain through toggle synchronizers, so each port sees its own copy of every flag, timed to its own clock.

Each port registers its read data. A read with the mailbox select high returns the opposite port's mailbox, zero-extended to the full data width. A read with the mailbox select low returns the word present on the port's FIFO output-register input. The interface has no valid/ready handshake. A port issues an operation by qualifying one clock edge with its strobes. Back-pressure exists only as the writer's own full flag: a write to a full mailbox is dropped, and the writer must wait for its copy of the flag to fall.

Each mailbox has its own active-low reset. The reset acts on that mailbox's flops in both domains and on the read-data register of the port that reads that mailbox.

Top module: `mbox_pair_top`

## Requirements
- R1: A port acts on a rising edge of its clock only when its chip select (`*_cs_n`) is 0 and its enable is 1. Otherwise it changes no flag, no mailbox and no read data.
- R2: When port A makes a write (`a_wr`=1) with `a_mb_sel`=1 and mailbox 1 is empty, the lower MB_W bits of `a_wdata` are stored. `mb1_full_a` is 1 after that edge, and `mb1_full_b` becomes 1 within 3 later `clk_b` edges.
- R3: When port B makes a write (`b_rd`=0) with `b_mb_sel`=1 and mailbox 2 is empty, `b_wdata` is stored. `mb2_full_b` is 1 after that edge, and `mb2_full_a` becomes 1 within 3 later `clk_a` edges.
- R4: A write to a mailbox whose writer-side flag is 1 is ignored, and the stored word is kept.
- R5: A read with the mailbox select high by the reading port, while its view of that mailbox is full, clears that view at the same edge. The writer's view clears within 3 later writer-clock edges. A mailbox read while empty leaves both flags at 0.
- R6: `rst_mb1_n`=0 forces `mb1_full_a` and `mb1_full_b` to 0 and `b_rdata` to 0. `rst_mb2_n`=0 forces `mb2_full_a` and `mb2_full_b` to 0 and `a_rdata` to 0.
- R7: A mailbox read (select 1) loads the port's read data at that edge: `a_rdata` takes mailbox 2 and `b_rdata` takes mailbox 1. The mailbox occupies bits MB_W-1:0, and bits DATA_W-1:MB_W read 0.
- R8: A read with the mailbox select 0 loads the full DATA_W-bit `*_fifo_q` into the port's read data at that edge.
- R9: The read data of a port holds its value on every edge that does not carry a read on that port, including write edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_mb1_n | input | 1 | Async active-low reset of mailbox 1 and the port B read register |
| rst_mb2_n | input | 1 | Async active-low reset of mailbox 2 and the port A read register |
| a_cs_n | input | 1 | Port A select, active low |
| a_en | input | 1 | Port A enable |
| a_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_mb_sel | input | 1 | Port A target: 1 mailbox, 0 FIFO |
| a_wdata | input | MB_W | Port A mailbox write data |
| a_fifo_q | input | DATA_W | Port A FIFO output register value |
| a_rdata | output | DATA_W | Port A registered read data |
| b_cs_n | input | 1 | Port B select, active low |
| b_en | input | 1 | Port B enable |
| b_rd | input | 1 | Port B direction: 1 read, 0 write |
| b_mb_sel | input | 1 | Port B target: 1 mailbox, 0 FIFO |
| b_wdata | input | MB_W | Port B mailbox write data |
| b_fifo_q | input | DATA_W | Port B FIFO output register value |
| b_rdata | output | DATA_W | Port B registered read data |
| mb1_full_a | output | 1 | Mailbox 1 full, port A view |
| mb1_full_b | output | 1 | Mailbox 1 full, port B view |
| mb2_full_a | output | 1 | Mailbox 2 full, port A view |
| mb2_full_b | output | 1 | Mailbox 2 full, port B view |

## Verification
Two events can coincide on one port. Port A can be collecting mailbox 2 at the same time as the clear of mailbox 1, which comes from port B, is still crossing into the `clk_a` domain. The bench fills both mailboxes and has port B drain mailbox 1. Port A then reads mailbox 2 on its next cycle, while the mailbox 1 clear is still in flight. The bench judges each effect on its own terms: `a_rdata` must show mailbox 2, `mb2_full_a` must drop at once, and `mb1_full_a` must still fall within its synchronizer window without disturbing the other mailbox.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_FIFO_WR,
    OP_FIFO_RD,
    OP_MB_WR,
    OP_MB_RD
  } port_op_e;

  // Qualify one port edge into a single operation code.
  function automatic port_op_e decode_op(input logic cs_n, input logic en,
                                         input logic mb_sel, input logic is_write);
    if (cs_n || !en) return OP_IDLE;
    if (mb_sel) return is_write ? OP_MB_WR : OP_MB_RD;
    return is_write ? OP_FIFO_WR : OP_FIFO_RD;
  endfunction

endpackage

// File: rtl/mbox_tog_sync.sv
module mbox_tog_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-2:0], d};
  end

  assign q = shreg[STAGES-1];
endmodule

// File: rtl/mbox_channel.sv
module mbox_channel #(
  parameter int MB_W        = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic            wclk,
  input  logic            rclk,
  input  logic            rst_n,
  input  logic            wr_req,
  input  logic [MB_W-1:0] wdata,
  input  logic            rd_req,
  output logic            full_w,
  output logic            full_r,
  output logic [MB_W-1:0] mb_q
);
  logic wr_tog, wr_tog_r;
  logic rd_tog, rd_tog_w;
  logic accept, clear;

  // Writer domain: the writer's own view blocks writes until the clear returns.
  assign full_w = wr_tog ^ rd_tog_w;
  assign accept = wr_req && !full_w;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wr_tog <= 1'b0;
      mb_q   <= '0;
    end else if (accept) begin
      wr_tog <= ~wr_tog;
      mb_q   <= wdata;
    end
  end

  mbox_tog_sync #(.STAGES(SYNC_STAGES)) u_sync_to_r (
    .clk(rclk), .rst_n(rst_n), .d(wr_tog), .q(wr_tog_r)
  );

  // Reader domain: a clear only happens when the reader sees the mailbox full.
  assign full_r = wr_tog_r ^ rd_tog;
  assign clear  = rd_req && full_r;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)     rd_tog <= 1'b0;
    else if (clear) rd_tog <= ~rd_tog;
  end

  mbox_tog_sync #(.STAGES(SYNC_STAGES)) u_sync_to_w (
    .clk(wclk), .rst_n(rst_n), .d(rd_tog), .q(rd_tog_w)
  );

  // R2/R3: an accepted write shows up as full in the writer's view next edge
  p_write_sets_full_r2 : assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_req && !full_w) |=> full_w);

  // R4: a write while full leaves the stored word untouched
  p_full_write_ignored_r4 : assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_req && full_w) |=> $stable(mb_q));

  // R5: a reader access on a full mailbox empties the reader's view at once
  p_read_clears_r5 : assert property (@(posedge rclk) disable iff (!rst_n)
    (rd_req && full_r) |=> !full_r);

  // R4: the stored word never changes while the reader still sees it full
  p_data_steady_r4 : assert property (@(posedge rclk) disable iff (!rst_n)
    (full_r && $past(full_r)) |-> $stable(mb_q));
endmodule

// File: rtl/mbox_rdmux.sv
module mbox_rdmux #(
  parameter int DATA_W = 36,
  parameter int MB_W   = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              sel_mb,
  input  logic [MB_W-1:0]   mb_d,
  input  logic [DATA_W-1:0] fifo_d,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= sel_mb ? DATA_W'(mb_d) : fifo_d;
  end

  // R7: bits above the mailbox width read zero after a mailbox read
  p_upper_zero_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel_mb) |=> ((rdata >> MB_W) == '0));

  // R9: no read on this port, no change of its read data
  p_hold_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/mbox_pair_top.sv
module mbox_pair_top
  import mbox_pkg::*;
#(
  parameter int DATA_W      = 36,
  parameter int MB_W        = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic              rst_mb1_n,
  input  logic              rst_mb2_n,
  input  logic              a_cs_n,
  input  logic              a_en,
  input  logic              a_wr,
  input  logic              a_mb_sel,
  input  logic [MB_W-1:0]   a_wdata,
  input  logic [DATA_W-1:0] a_fifo_q,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_cs_n,
  input  logic              b_en,
  input  logic              b_rd,
  input  logic              b_mb_sel,
  input  logic [MB_W-1:0]   b_wdata,
  input  logic [DATA_W-1:0] b_fifo_q,
  output logic [DATA_W-1:0] b_rdata,
  output logic              mb1_full_a,
  output logic              mb1_full_b,
  output logic              mb2_full_a,
  output logic              mb2_full_b
);
  localparam int NPORT = 2;

  // Index 0 is port A / mailbox 1, index 1 is port B / mailbox 2.
  // Channel i is written by port i and read by the other port.
  logic              clk_v    [NPORT];
  logic              rst_v    [NPORT];
  port_op_e          op_v     [NPORT];
  logic [MB_W-1:0]   wdata_v  [NPORT];
  logic [DATA_W-1:0] fifo_v   [NPORT];
  logic [DATA_W-1:0] rdata_v  [NPORT];
  logic [MB_W-1:0]   mb_q_v   [NPORT];
  logic              full_w_v [NPORT];
  logic              full_r_v [NPORT];

  assign clk_v[0]   = clk_a;
  assign clk_v[1]   = clk_b;
  assign rst_v[0]   = rst_mb1_n;
  assign rst_v[1]   = rst_mb2_n;
  assign op_v[0]    = decode_op(a_cs_n, a_en, a_mb_sel, a_wr);
  assign op_v[1]    = decode_op(b_cs_n, b_en, b_mb_sel, !b_rd);
  assign wdata_v[0] = a_wdata;
  assign wdata_v[1] = b_wdata;
  assign fifo_v[0]  = a_fifo_q;
  assign fifo_v[1]  = b_fifo_q;

  for (genvar i = 0; i < NPORT; i++) begin : g_lane
    localparam int PEER = NPORT - 1 - i;

    mbox_channel #(.MB_W(MB_W), .SYNC_STAGES(SYNC_STAGES)) u_chan (
      .wclk   (clk_v[i]),
      .rclk   (clk_v[PEER]),
      .rst_n  (rst_v[i]),
      .wr_req (op_v[i] == OP_MB_WR),
      .wdata  (wdata_v[i]),
      .rd_req (op_v[PEER] == OP_MB_RD),
      .full_w (full_w_v[i]),
      .full_r (full_r_v[i]),
      .mb_q   (mb_q_v[i])
    );

    // Port i collects the peer's mailbox; its register shares that mailbox's reset.
    mbox_rdmux #(.DATA_W(DATA_W), .MB_W(MB_W)) u_rdmux (
      .clk    (clk_v[i]),
      .rst_n  (rst_v[PEER]),
      .rd_en  (op_v[i] == OP_MB_RD || op_v[i] == OP_FIFO_RD),
      .sel_mb (op_v[i] == OP_MB_RD),
      .mb_d   (mb_q_v[PEER]),
      .fifo_d (fifo_v[i]),
      .rdata  (rdata_v[i])
    );
  end

  assign a_rdata    = rdata_v[0];
  assign b_rdata    = rdata_v[1];
  assign mb1_full_a = full_w_v[0];
  assign mb1_full_b = full_r_v[0];
  assign mb2_full_b = full_w_v[1];
  assign mb2_full_a = full_r_v[1];

  // R1: an unqualified port A edge never raises the mailbox 1 flag
  p_idle_no_set_r1 : assert property (@(posedge clk_a) disable iff (!rst_mb1_n)
    ((a_cs_n || !a_en) && !mb1_full_a) |=> !mb1_full_a);
endmodule

// File: tb/mbox_pair_top_tb_top.sv
`timescale 1ns/100ps
module mbox_pair_top_tb_top;
  localparam int DW = 36;
  localparam int MW = 18;
  localparam logic [DW-1:0] MASK = (36'h1 << MW) - 36'h1;

  logic clk_a = 0, clk_b = 0;
  logic rst_mb1_n = 0, rst_mb2_n = 0;
  logic a_cs_n = 1, a_en = 0, a_wr = 0, a_mb_sel = 0;
  logic b_cs_n = 1, b_en = 0, b_rd = 1, b_mb_sel = 0;
  logic [MW-1:0] a_wdata = '0, b_wdata = '0;
  logic [DW-1:0] a_fifo_q = '0, b_fifo_q = '0;
  logic [DW-1:0] a_rdata, b_rdata;
  logic mb1_full_a, mb1_full_b, mb2_full_a, mb2_full_b;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk_a = ~clk_a;   // 200 MHz
  always #3.5 clk_b = ~clk_b;   // unrelated second clock

  mbox_pair_top #(.DATA_W(DW), .MB_W(MW)) dut_i (.*);

  // Each row: mailbox 1 word, mailbox 2 word, port A FIFO word, port B FIFO word
  localparam logic [DW-1:0] VEC [6][4] = '{
    '{36'h0_0001_2345, 36'h0_0002_0001, 36'hF_0000_0001, 36'hA_5A5A_5A5A},
    '{36'hF_FFFF_FFFF, 36'h0_0000_0000, 36'h0_0000_0000, 36'hF_FFFF_FFFF},
    '{36'h0_0000_0001, 36'h0_0003_FFFF, 36'h8_0000_0000, 36'h0_0000_0001},
    '{36'h5_5555_5555, 36'hA_AAAA_AAAA, 36'h1_2345_6789, 36'h9_8765_4321},
    '{36'h0_0002_AAAA, 36'h0_0001_5555, 36'h0_0003_FFFF, 36'hC_0000_0003},
    '{36'h7_0000_8000, 36'h0_0000_0100, 36'h3_3333_3333, 36'h6_6666_6666}
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic a_cycle(input logic cs_n, input logic en, input logic sel,
                         input logic wr, input logic [MW-1:0] d, input logic [DW-1:0] fq);
    @(negedge clk_a);
    a_cs_n = cs_n; a_en = en; a_mb_sel = sel; a_wr = wr; a_wdata = d; a_fifo_q = fq;
    @(posedge clk_a);
    @(negedge clk_a);
    a_cs_n = 1; a_en = 0;
  endtask

  task automatic b_cycle(input logic cs_n, input logic en, input logic sel,
                         input logic rd, input logic [MW-1:0] d, input logic [DW-1:0] fq);
    @(negedge clk_b);
    b_cs_n = cs_n; b_en = en; b_mb_sel = sel; b_rd = rd; b_wdata = d; b_fifo_q = fq;
    @(posedge clk_b);
    @(negedge clk_b);
    b_cs_n = 1; b_en = 0;
  endtask

  // which: 0 mb1_full_a, 1 mb1_full_b, 2 mb2_full_a, 3 mb2_full_b
  function automatic logic flag(input int which);
    case (which)
      0: return mb1_full_a;
      1: return mb1_full_b;
      2: return mb2_full_a;
      default: return mb2_full_b;
    endcase
  endfunction

  task automatic wait_flag(input int which, input logic exp, input string req);
    for (int k = 0; k < 4; k++) begin
      if (flag(which) == exp) break;
      if (which == 0 || which == 2) @(negedge clk_a);
      else @(negedge clk_b);
    end
    check(req, DW'(flag(which)), DW'(exp));
  endtask

  task automatic idle_cycles(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_a);
      @(negedge clk_b);
    end
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R6: state under reset
    #50;
    check("R6 mb1_full_a in reset", DW'(mb1_full_a), 0);
    check("R6 mb1_full_b in reset", DW'(mb1_full_b), 0);
    check("R6 mb2_full_a in reset", DW'(mb2_full_a), 0);
    check("R6 mb2_full_b in reset", DW'(mb2_full_b), 0);
    check("R6 a_rdata in reset", a_rdata, 0);
    check("R6 b_rdata in reset", b_rdata, 0);
    #51;
    rst_mb1_n = 1; rst_mb2_n = 1;
    idle_cycles(2);

    // Table walk: both directions plus FIFO reads
    for (int v = 0; v < 6; v++) begin
      a_cycle(0, 1, 1, 1, VEC[v][0][MW-1:0], '0);
      check("R2 mb1_full_a after write", DW'(mb1_full_a), 1);
      wait_flag(1, 1, "R2 mb1_full_b follows");
      b_cycle(0, 1, 1, 1, '0, '0);
      check("R7 b_rdata mailbox 1", b_rdata, VEC[v][0] & MASK);
      check("R5 mb1_full_b cleared", DW'(mb1_full_b), 0);
      wait_flag(0, 0, "R5 mb1_full_a follows");

      b_cycle(0, 1, 1, 0, VEC[v][1][MW-1:0], '0);
      check("R3 mb2_full_b after write", DW'(mb2_full_b), 1);
      wait_flag(2, 1, "R3 mb2_full_a follows");
      a_cycle(0, 1, 1, 0, '0, '0);
      check("R7 a_rdata mailbox 2", a_rdata, VEC[v][1] & MASK);
      check("R5 mb2_full_a cleared", DW'(mb2_full_a), 0);
      wait_flag(3, 0, "R5 mb2_full_b follows");

      a_cycle(0, 1, 0, 0, '0, VEC[v][2]);
      check("R8 a_rdata FIFO word", a_rdata, VEC[v][2]);
      b_cycle(0, 1, 0, 1, '0, VEC[v][3]);
      check("R8 b_rdata FIFO word", b_rdata, VEC[v][3]);
    end

    // R1: deselected or disabled edges do nothing
    a_cycle(1, 1, 1, 1, 18'h1_1111, '0);
    a_cycle(0, 0, 1, 1, 18'h2_2222, '0);
    idle_cycles(4);
    check("R1 mb1_full_a after unqualified writes", DW'(mb1_full_a), 0);
    check("R1 mb1_full_b after unqualified writes", DW'(mb1_full_b), 0);
    b_cycle(1, 1, 0, 1, '0, 36'h1_0000_0000);
    b_cycle(0, 0, 0, 1, '0, 36'h2_0000_0000);
    check("R1 b_rdata after unqualified reads", b_rdata, VEC[5][3]);

    // R9: a write edge leaves the port's read data alone
    a_cycle(0, 1, 1, 1, 18'h0_0ABC, '0);
    check("R9 a_rdata held over write", a_rdata, VEC[5][2]);

    // R4: second write while full is dropped
    a_cycle(0, 1, 1, 1, 18'h0_0DEF, '0);
    wait_flag(1, 1, "R4 mb1_full_b set");
    b_cycle(0, 1, 1, 1, '0, '0);
    check("R4 first word kept", b_rdata, 36'h0_0000_0ABC);
    wait_flag(0, 0, "R4 mb1_full_a clears");

    // R5: reading an empty mailbox leaves both flags low
    b_cycle(0, 1, 1, 1, '0, '0);
    idle_cycles(4);
    check("R5 mb1_full_b after empty read", DW'(mb1_full_b), 0);
    check("R5 mb1_full_a after empty read", DW'(mb1_full_a), 0);
    a_cycle(0, 1, 1, 1, 18'h1_2121, '0);
    wait_flag(1, 1, "R5 flag works after empty read");
    b_cycle(0, 1, 1, 1, '0, '0);
    check("R5 data after empty read", b_rdata, 36'h0_0001_2121);
    wait_flag(0, 0, "R5 writer view clears");

    // Coinciding events: port A reads mailbox 2 while mailbox 1 clear is in flight
    a_cycle(0, 1, 1, 1, 18'h3_0303, '0);
    b_cycle(0, 1, 1, 0, 18'h0_4444, '0);
    wait_flag(1, 1, "R2 mb1 full seen by B");
    wait_flag(2, 1, "R3 mb2 full seen by A");
    b_cycle(0, 1, 1, 1, '0, '0);
    a_cycle(0, 1, 1, 0, '0, '0);
    check("R7 a_rdata during clear crossing", a_rdata, 36'h0_0000_4444);
    check("R5 mb2_full_a drops at once", DW'(mb2_full_a), 0);
    check("R7 b_rdata during clear crossing", b_rdata, 36'h0_0003_0303);
    wait_flag(0, 0, "R5 mb1_full_a clears");
    wait_flag(3, 0, "R5 mb2_full_b clears");

    // R6: reset of mailbox 1 while full, mailbox 2 side untouched
    a_cycle(0, 1, 1, 1, 18'h3_ABCD, '0);
    wait_flag(1, 1, "R6 mb1 full before reset");
    b_cycle(0, 1, 0, 1, '0, 36'hF_0000_0001);
    @(negedge clk_a); #0.7;
    rst_mb1_n = 0;
    #0.1;
    check("R6 mb1_full_a by reset", DW'(mb1_full_a), 0);
    check("R6 mb1_full_b by reset", DW'(mb1_full_b), 0);
    check("R6 b_rdata by reset", b_rdata, 0);
    check("R6 a_rdata unaffected", a_rdata, 36'h0_0000_4444);
    idle_cycles(2);
    @(negedge clk_a); #0.7;
    rst_mb1_n = 1;
    idle_cycles(1);
    a_cycle(0, 1, 1, 1, 18'h0_7777, '0);
    wait_flag(1, 1, "R6 usable after reset");
    b_cycle(0, 1, 1, 1, '0, '0);
    check("R6 data after reset", b_rdata, 36'h0_0000_7777);

    idle_cycles(2);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule